// File: doc/BRIEF.md
# Serial Update Controller for a Two-Channel Buffered DAC

This block sits on the host side of a two-channel, double-buffered digital-to-analog converter. A request carries a channel select, a gain choice, an output-enable flag and a 12-bit code, and it arrives on a valid/ready handshake. The controller turns each accepted request into one 16-bit serial word and sends it with chip select, serial clock and serial data in SPI mode 0: the clock idles low and data changes on its falling edge. After the word it can pulse an active-low load strobe, which moves the converter's input buffers into its output stage.

Every minimum interval on the serial link is a parameter counted in system clock cycles. This covers the clock phases, the lead from select to the first edge, the trail, the select-high gap, the strobe setup and the strobe width. The integrator rounds each nanosecond limit up for the clock in use. When a request carries the sync flag, the strobe is held back until one more word has gone out, so both channels change output together.

Top module: `dac_frame_sender`

## Requirements
- R1: While reset is active and directly after it: cs_n = 1, sclk = 0, latch_n = 1 and req_ready = 1.
- R2: The word is sent MSB first and read on each rising sclk. Bits 11..0 hold req_code, bit 12 holds req_enable, bit 13 holds req_unity (1 = unity gain, 0 = double gain), bit 14 is always 0, and bit 15 holds req_chan_b (1 = channel B).
- R3: Each word has exactly 16 rising sclk edges, and sclk is high only while cs_n is low.
- R4: Each sclk high phase and each low phase between rising edges lasts exactly SCK_HALF_CYC cycles, and sdo does not change while sclk is high.
- R5: The first rising sclk comes LEAD_CYC cycles after cs_n falls. cs_n rises SCK_HALF_CYC + TRAIL_CYC cycles after the last rising sclk. cs_n then stays high for at least CS_HIGH_CYC cycles.
- R6: When a strobe is due, latch_n falls CS_HIGH_CYC + LATCH_SETUP_CYC cycles after cs_n rises, stays low for exactly LATCH_WIDTH_CYC cycles, and is low only while cs_n is high.
- R7: A word sent with req_sync = 1 while no sync word is pending gets no strobe; the next word always gets one. A word with req_sync = 0 always gets one.
- R8: req_ready is low from acceptance until the frame is done. With a strobe, that is the cycle latch_n returns high. Without one, it is CS_HIGH_CYC cycles after cs_n rises. Requests held valid meanwhile wait and are sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_chan_b | input | 1 | 1 selects channel B |
| req_unity | input | 1 | 1 selects unity gain |
| req_enable | input | 1 | 1 enables the channel output |
| req_sync | input | 1 | Defer the strobe to the following word |
| req_code | input | CODE_W | Conversion code |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the converter |
| latch_n | output | 1 | Active-low output load strobe |

## Verification
The hardest case to reach from the ports is the deferred strobe. A pending sync word has to be paired with a later word that arrives back-to-back while ready is low, and a second sync word must still force the strobe. The stimulus holds valid across frame boundaries so that requests queue behind busy frames. It runs sync/sync and sync/plain pairs, and a scoreboard records for each word whether a strobe is expected. The monitor times each cs_n, sclk and latch_n edge in clock cycles against the parameters.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SCK_HI,
    ST_SCK_LO,
    ST_TRAIL,
    ST_GAP,
    ST_LSETUP,
    ST_LPULSE
  } dfs_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dfs_interval_timer.sv
module dfs_interval_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dfs_frame_shifter.sv
module dfs_frame_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  output logic               msb,
  output logic               last_bit
);

  localparam int unsigned BW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [BW-1:0]      left_q, left_d;

  always_comb begin
    sreg_d = sreg_q;
    left_d = left_q;
    if (load) begin
      sreg_d = frame;
      left_d = BW'(FRAME_W);
    end else if (shift) begin
      sreg_d = {sreg_q[FRAME_W-2:0], 1'b0};
      left_d = left_q - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else begin
      sreg_q <= sreg_d;
      left_q <= left_d;
    end
  end

  assign msb      = sreg_q[FRAME_W-1];
  assign last_bit = (left_q == BW'(1));

endmodule

// File: rtl/dac_frame_sender.sv
module dac_frame_sender #(
  parameter int unsigned CODE_W          = 12,
  parameter int unsigned SCK_HALF_CYC    = 2,
  parameter int unsigned LEAD_CYC        = 2,
  parameter int unsigned TRAIL_CYC       = 1,
  parameter int unsigned CS_HIGH_CYC     = 1,
  parameter int unsigned LATCH_SETUP_CYC = 2,
  parameter int unsigned LATCH_WIDTH_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_chan_b,
  input  logic              req_unity,
  input  logic              req_enable,
  input  logic              req_sync,
  input  logic [CODE_W-1:0] req_code,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo,
  output logic              latch_n
);

  import dfs_pkg::*;

  localparam int unsigned FRAME_W = CODE_W + 4;
  localparam int unsigned MAX_CYC = max2(max2(max2(SCK_HALF_CYC, LEAD_CYC), max2(TRAIL_CYC, CS_HIGH_CYC)),
                                         max2(LATCH_SETUP_CYC, LATCH_WIDTH_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  dfs_state_e       state_q, state_d;
  logic             pend_q, pend_d;
  logic             due_q, due_d;
  logic             cs_n_q, sclk_q, latch_n_q;
  logic             cs_n_d, sclk_d, latch_n_d;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             sh_load, sh_shift, sh_msb, sh_last;
  logic [FRAME_W-1:0] frame_word;

  assign frame_word = {req_chan_b, 1'b0, req_unity, req_enable, req_code};

  dfs_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dfs_frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (sh_load),
    .frame    (frame_word),
    .shift    (sh_shift),
    .msb      (sh_msb),
    .last_bit (sh_last)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    due_d    = due_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d  = ST_LEAD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LEAD_CYC - 1);
          sh_load  = 1'b1;
          due_d    = !req_sync || pend_q;
          pend_d   = req_sync && !pend_q;
        end
      end
      ST_LEAD: begin
        if (tmr_expired) begin
          state_d  = ST_SCK_HI;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SCK_HALF_CYC - 1);
        end
      end
      ST_SCK_HI: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (sh_last) begin
            state_d = ST_TRAIL;
            tmr_val = CNT_W'(TRAIL_CYC - 1);
          end else begin
            state_d  = ST_SCK_LO;
            tmr_val  = CNT_W'(SCK_HALF_CYC - 1);
            sh_shift = 1'b1;
          end
        end
      end
      ST_SCK_LO: begin
        if (tmr_expired) begin
          state_d  = ST_SCK_HI;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SCK_HALF_CYC - 1);
        end
      end
      ST_TRAIL: begin
        if (tmr_expired) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(CS_HIGH_CYC - 1);
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          if (due_q) begin
            state_d  = ST_LSETUP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(LATCH_SETUP_CYC - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_LSETUP: begin
        if (tmr_expired) begin
          state_d  = ST_LPULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LATCH_WIDTH_CYC - 1);
        end
      end
      ST_LPULSE: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // output decode of the next state, registered below
  always_comb begin
    cs_n_d    = !((state_d == ST_LEAD) || (state_d == ST_SCK_HI) ||
                  (state_d == ST_SCK_LO) || (state_d == ST_TRAIL));
    sclk_d    = (state_d == ST_SCK_HI);
    latch_n_d = (state_d != ST_LPULSE);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      due_q     <= 1'b0;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b0;
      latch_n_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      due_q     <= due_d;
      cs_n_q    <= cs_n_d;
      sclk_q    <= sclk_d;
      latch_n_q <= latch_n_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign cs_n      = cs_n_q;
  assign sclk      = sclk_q;
  assign latch_n   = latch_n_q;
  assign sdo       = sh_msb;

endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned LATCH_W  = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic latch_n,
  input logic req_ready
);

  int unsigned hi_run;
  int unsigned lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= sclk ? hi_run + 1 : 0;
      lo_run <= !latch_n ? lo_run + 1 : 0;
    end
  end

  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  assert_high_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run == SCK_HALF));

  assert_strobe_outside_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_n |-> cs_n);

  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_n) |-> (lo_run == LATCH_W));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n || !latch_n) |-> !req_ready);

endmodule

bind dac_frame_sender dfs_checker #(
  .SCK_HALF (SCK_HALF_CYC),
  .LATCH_W  (LATCH_WIDTH_CYC)
) u_dfs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .sdo       (sdo),
  .latch_n   (latch_n),
  .req_ready (req_ready)
);

// File: tb/test_dac_frame_sender.sv
module test_dac_frame_sender;

  localparam int CODE_W  = 12;
  localparam int HALF    = 2;
  localparam int LEAD    = 3;
  localparam int TRAIL   = 1;
  localparam int CSHIGH  = 2;
  localparam int LSETUP  = 2;
  localparam int LWIDTH  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready;
  logic              req_chan_b, req_unity, req_enable, req_sync;
  logic [CODE_W-1:0] req_code;
  logic              cs_n, sclk, sdo, latch_n;

  always #10 clk = ~clk;

  dac_frame_sender #(
    .CODE_W(CODE_W), .SCK_HALF_CYC(HALF), .LEAD_CYC(LEAD), .TRAIL_CYC(TRAIL),
    .CS_HIGH_CYC(CSHIGH), .LATCH_SETUP_CYC(LSETUP), .LATCH_WIDTH_CYC(LWIDTH)
  ) i_dac_frame_sender (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan_b(req_chan_b), .req_unity(req_unity), .req_enable(req_enable),
    .req_sync(req_sync), .req_code(req_code), .cs_n(cs_n), .sclk(sclk),
    .sdo(sdo), .latch_n(latch_n)
  );

  typedef struct { logic [15:0] word; bit strobe; } exp_t;
  exp_t exp_q[$];

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  bit  pend_model = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // ---------------- monitor ----------------
  int  cyc = 0;
  bit  p_cs = 1, p_sclk = 0, p_latch = 1, p_ready = 1;
  logic [15:0] word;
  int  nbits, cs_fall_c, cs_rise_c = -100, rise_c, fall_c, lfall_c;
  bit  strobe_pending = 0, last_strobe = 0, mon_on = 0;

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (!cs_n && p_cs) begin
        word = 0; nbits = 0; cs_fall_c = cyc;
        chk(cyc - cs_rise_c >= CSHIGH, "R5 cs_n high gap", cyc - cs_rise_c, CSHIGH);
        chk(!strobe_pending, "R6 strobe missing before next frame", strobe_pending, 0);
      end
      if (sclk && !p_sclk) begin
        chk(!cs_n, "R3 sclk rise outside frame", cs_n, 0);
        word = {word[14:0], sdo};
        nbits++;
        if (nbits == 1) chk(cyc - cs_fall_c == LEAD, "R5 lead", cyc - cs_fall_c, LEAD);
        else            chk(cyc - fall_c == HALF, "R4 low phase", cyc - fall_c, HALF);
        rise_c = cyc;
      end
      if (!sclk && p_sclk) begin
        chk(cyc - rise_c == HALF, "R4 high phase", cyc - rise_c, HALF);
        fall_c = cyc;
      end
      if (cs_n && !p_cs) begin
        exp_t e;
        chk(!sclk, "R3 sclk low at cs_n rise", sclk, 0);
        chk(cyc - rise_c == HALF + TRAIL, "R5 trail", cyc - rise_c, HALF + TRAIL);
        chk(nbits == 16, "R3 rising edge count", nbits, 16);
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected frame", word, 0);
        end else begin
          e = exp_q.pop_front();
          chk(word == e.word, "R2 frame word", word, e.word);
          strobe_pending = e.strobe;
          last_strobe    = e.strobe;
        end
        cs_rise_c = cyc;
      end
      if (!latch_n && p_latch) begin
        chk(strobe_pending, "R7 strobe not expected", 1, strobe_pending);
        chk(cyc - cs_rise_c == CSHIGH + LSETUP, "R6 strobe delay", cyc - cs_rise_c, CSHIGH + LSETUP);
        strobe_pending = 0;
        lfall_c = cyc;
      end
      if (latch_n && !p_latch)
        chk(cyc - lfall_c == LWIDTH, "R6 strobe width", cyc - lfall_c, LWIDTH);
      if (req_ready && !p_ready) begin
        if (last_strobe) chk(latch_n && !p_latch, "R8 ready with strobe end", latch_n, 1);
        else chk(cyc - cs_rise_c == CSHIGH, "R8 ready after gap", cyc - cs_rise_c, CSHIGH);
      end
      if (req_ready && (!cs_n || !latch_n))
        chk(0, "R8 ready during busy", req_ready, 0);
    end
    p_cs = cs_n; p_sclk = sclk; p_latch = latch_n; p_ready = req_ready;
  end

  // ---------------- driver ----------------
  task automatic send(input bit b, input bit u, input bit en, input logic [11:0] code, input bit sy);
    exp_t e;
    req_valid = 1; req_chan_b = b; req_unity = u; req_enable = en; req_code = code; req_sync = sy;
    e.word   = {b, 1'b0, u, en, code};
    e.strobe = !sy || pend_model;
    pend_model = sy && !pend_model;
    exp_q.push_back(e);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(!req_ready, "R8 ready low after accept", req_ready, 0);
  endtask

  task automatic release_req();
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !req_ready || !cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!strobe_pending, "R6 strobe outstanding", strobe_pending, 0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_chan_b = 0; req_unity = 0; req_enable = 0;
    req_sync = 0; req_code = '0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1,    "R1 cs_n in reset", cs_n, 1);
    chk(sclk === 1'b0,    "R1 sclk in reset", sclk, 0);
    chk(latch_n === 1'b1, "R1 latch_n in reset", latch_n, 1);
    chk(req_ready === 1'b1, "R1 ready in reset", req_ready, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && latch_n === 1'b1 && req_ready === 1'b1,
        "R1 idle after reset", {cs_n, sclk, latch_n, req_ready}, 4'b1011);
    mon_on = 1;

    // R2 R6: channel A, double gain, enabled
    send(0, 0, 1, 12'hABC, 0); release_req(); drain();
    // R2: channel B, unity, disabled, full code
    send(1, 1, 0, 12'hFFF, 0); release_req(); drain();
    // R7: sync word then plain word, back-to-back (R8 ordering)
    send(1, 0, 1, 12'h000, 1);
    send(0, 1, 0, 12'h555, 0); release_req(); drain();
    // R7: two sync words, second one carries the strobe
    send(0, 0, 1, 12'h123, 1);
    send(1, 0, 1, 12'h456, 1); release_req(); drain();
    // R8: three plain words held valid
    send(0, 0, 1, 12'h000, 0);
    send(0, 1, 1, 12'hFFF, 0);
    send(1, 1, 1, 12'h801, 0); release_req(); drain();
    // R7: lone sync word, no strobe, then plain word
    send(1, 1, 1, 12'h7E5, 1); release_req(); drain();
    chk(latch_n === 1'b1, "R7 no strobe after lone sync word", latch_n, 1);
    send(0, 0, 0, 12'h00F, 0); release_req(); drain();

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule